// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. The analog front end outside the chip has an integrator, a reference switch and a zero-crossing comparator, and it is steered by a two-bit phase code. The sequencer drives that code through four phases: auto zero, signal integrate, reference deintegrate and integrator zero. It times the fixed phases with a cycle counter and measures how long the deintegrate phase lasts. That length is the magnitude of the result. The comparator level sampled at the end of integration is the sign.

A conversion is requested on a valid/ready stream input that also carries the channel number for a four-input differential multiplexer. Auto zero is the idle phase. A request is accepted only after the front end has spent a minimum time in auto zero. The request may be held valid early and simply waits until ready rises. The result comes out as a one-cycle strobe carrying the sign, the count and two fault flags. The result side has no back-pressure: the consumer must take each result in the strobe cycle. The reported fields then stay unchanged until the next strobe.

The comparator input is asynchronous. It passes through a flop synchronizer before any decision is taken from it. Faults never leave the front end stuck outside auto zero. A deintegrate phase that runs too long, or an integrator-zero phase that never sees the comparator return high, still ends the conversion with a strobe.

Top module: `dual_slope_seq`

## Requirements
- R1: The phase code {phase_a,phase_b} means 00 = integrator zero, 01 = auto zero, 10 = signal integrate, 11 = reference deintegrate. During and directly after reset the code is 01, and start_ready and res_valid are low.
- R2: Only these phase steps are taken: 01→10, 10→11, 11→00, 00→01, and 11→01 on overrange. A normal conversion visits 01, 10, 11, 00 and returns to 01.
- R3: start_ready is high only in auto zero, and only once the sequencer has been in auto zero for at least AZ_CYCLES clock cycles. A request is accepted on a rising edge where start_valid and start_ready are both high, and the phase is 10 in the next cycle. A request held while ready is low waits and is not lost.
- R4: Signal integrate lasts exactly INT_CYCLES clock cycles.
- R5: res_sign is the synchronized comparator level in the last integrate cycle (1 = positive input). Comparator activity earlier in integrate does not affect it.
- R6: Suppose the comparator input falls between rising edges d-1 and d, where edge 0 is the one that entered deintegrate. Then res_count = d with the default SYNC_ADJ of 1, floored at 0. Deintegrate then moves to integrator zero.
- R7: If deintegrate lasts 2×INT_CYCLES+DEINT_MARGIN cycles with no falling edge, the phase goes straight to 01 and the strobe reports res_over = 1 and res_count = 2×INT_CYCLES+DEINT_MARGIN.
- R8: Integrator zero ends as soon as the synchronized comparator is high. The phase is 01 from the third rising edge that samples the comparator input high.
- R9: If integrator zero lasts IZ_TIMEOUT cycles without the comparator returning high, the phase goes to 01 and the strobe reports res_tmo = 1.
- R10: res_valid is a one-cycle pulse in the first cycle back in auto zero after a conversion. res_sign, res_count, res_over and res_tmo change only in a strobe cycle.
- R11: chan_sel takes the start_chan value at acceptance (00..11 = channels 1..4) and holds it until the next accepted request.
- R12: The comparator input has no effect while the phase is auto zero: phase, start_ready and the results follow only the timer and the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Conversion request valid |
| start_ready | output | 1 | Request can be accepted |
| start_chan | input | 2 | Channel for the requested conversion |
| cmp_in | input | 1 | Asynchronous zero-crossing comparator level |
| phase_a | output | 1 | Phase code, upper bit |
| phase_b | output | 1 | Phase code, lower bit |
| chan_sel | output | 2 | Multiplexer channel select |
| res_valid | output | 1 | One-cycle result strobe |
| res_sign | output | 1 | Sign of the result, 1 = positive |
| res_count | output | CNT_W | Deintegrate count |
| res_over | output | 1 | Deintegrate overrange |
| res_tmo | output | 1 | Integrator-zero timeout |

## Verification
The hardest cases to reach from the ports are the two fault exits and the exact count latency. Both depend on when the comparator moves relative to the phase the block has chosen. The bench therefore closes the loop with a behavioural integrator. The integrator charges with a signed input step during integrate, discharges at a reference rate during deintegrate, and recovers at a chosen rate during integrator zero. The bench drives the comparator from the sign of that integrator. An input large enough to outrun the deintegrate limit produces an overrange. A very slow recovery rate makes the overshoot outlast the integrator-zero timeout. The bench records the deintegrate cycle in which it let the comparator fall and compares the reported count with that cycle. Comparator noise during auto zero and early integrate checks that those samples are ignored.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Phase code driven onto the front end; bit 1 is phase_a, bit 0 is phase_b.
  typedef enum logic [1:0] {
    PH_IZ    = 2'b00,
    PH_AZ    = 2'b01,
    PH_INT   = 2'b10,
    PH_DEINT = 2'b11
  } phase_t;

  localparam int CHAN_W = 2;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dss_cmp_sync.sv
module dss_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic fall
);

  // pipe[0..STAGES-1] is the synchronizer, pipe[STAGES] holds the previous level.
  logic pipe [STAGES+1];

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= 1'b0;
          else        pipe[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= 1'b0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign level = pipe[STAGES-1];
  assign fall  = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/dss_phase_timer.sv
module dss_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/dss_result.sv
module dss_result #(
  parameter int W     = 8,
  parameter int LIMIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_sign,
  input  logic         sign_in,
  input  logic         cap_fall,
  input  logic [W-1:0] fall_cnt,
  input  logic         cap_over,
  input  logic         iz_done,
  input  logic         iz_tmo,
  output logic         res_valid,
  output logic         res_sign,
  output logic [W-1:0] res_count,
  output logic         res_over,
  output logic         res_tmo
);

  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic         stg_sign;
  logic [W-1:0] stg_count;
  logic         finish;

  assign finish = cap_over | iz_done | iz_tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_sign  <= 1'b0;
      stg_count <= '0;
      res_valid <= 1'b0;
      res_sign  <= 1'b0;
      res_count <= '0;
      res_over  <= 1'b0;
      res_tmo   <= 1'b0;
    end else begin
      res_valid <= finish;
      if (take_sign) stg_sign  <= sign_in;
      if (cap_fall)  stg_count <= fall_cnt;
      if (cap_over) begin
        res_sign  <= stg_sign;
        res_count <= LIM_V;
        res_over  <= 1'b1;
        res_tmo   <= 1'b0;
      end else if (iz_done || iz_tmo) begin
        res_sign  <= stg_sign;
        res_count <= stg_count;
        res_over  <= 1'b0;
        res_tmo   <= iz_tmo;
      end
    end
  end

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable({res_sign, res_count, res_over, res_tmo}));

  a_r7_over_count: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_over) |-> (res_count == LIM_V && !res_tmo));

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int INT_CYCLES   = 1000,
  parameter int AZ_CYCLES    = 1000,
  parameter int DEINT_MARGIN = 32,
  parameter int IZ_TIMEOUT   = 256,
  parameter int SYNC_STAGES  = 2,
  parameter int SYNC_ADJ     = 1,
  localparam int DEINT_LIMIT = 2 * INT_CYCLES + DEINT_MARGIN,
  localparam int CNT_W = $clog2(dss_pkg::max4(INT_CYCLES, AZ_CYCLES, DEINT_LIMIT, IZ_TIMEOUT) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [1:0]        start_chan,
  input  logic              cmp_in,
  output logic              phase_a,
  output logic              phase_b,
  output logic [1:0]        chan_sel,
  output logic              res_valid,
  output logic              res_sign,
  output logic [CNT_W-1:0]  res_count,
  output logic              res_over,
  output logic              res_tmo
);

  localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_CYCLES - 1);
  localparam logic [CNT_W-1:0] DIN_LAST = CNT_W'(DEINT_LIMIT - 1);
  localparam logic [CNT_W-1:0] IZ_LAST  = CNT_W'(IZ_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] AZ_MIN   = CNT_W'(AZ_CYCLES);
  localparam logic [CNT_W-1:0] ADJ_V    = CNT_W'(SYNC_ADJ);
  localparam logic [CNT_W-1:0] LIMIT_V  = CNT_W'(DEINT_LIMIT);

  phase_t             ph_q, ph_d;
  logic [CNT_W-1:0]   t_q;
  logic [CNT_W-1:0]   fall_cnt;
  logic [CHAN_W-1:0]  chan_q;
  logic tmr_clr, accept, take_sign, cap_fall, cap_over, iz_done, iz_tmo;
  logic cmp_lvl, cmp_fall;

  dss_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (cmp_in),
    .level (cmp_lvl),
    .fall  (cmp_fall)
  );

  dss_phase_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (t_q)
  );

  assign start_ready = (ph_q == PH_AZ) && (t_q >= AZ_MIN);
  assign fall_cnt    = (t_q >= ADJ_V) ? (t_q - ADJ_V) : '0;

  always_comb begin
    ph_d      = ph_q;
    tmr_clr   = 1'b0;
    accept    = 1'b0;
    take_sign = 1'b0;
    cap_fall  = 1'b0;
    cap_over  = 1'b0;
    iz_done   = 1'b0;
    iz_tmo    = 1'b0;
    unique case (ph_q)
      PH_AZ: begin
        if (start_valid && start_ready) begin
          accept  = 1'b1;
          ph_d    = PH_INT;
          tmr_clr = 1'b1;
        end
      end
      PH_INT: begin
        if (t_q == INT_LAST) begin
          take_sign = 1'b1;
          ph_d      = PH_DEINT;
          tmr_clr   = 1'b1;
        end
      end
      PH_DEINT: begin
        if (cmp_fall) begin
          cap_fall = 1'b1;
          ph_d     = PH_IZ;
          tmr_clr  = 1'b1;
        end else if (t_q == DIN_LAST) begin
          cap_over = 1'b1;
          ph_d     = PH_AZ;
          tmr_clr  = 1'b1;
        end
      end
      PH_IZ: begin
        if (cmp_lvl) begin
          iz_done = 1'b1;
          ph_d    = PH_AZ;
          tmr_clr = 1'b1;
        end else if (t_q == IZ_LAST) begin
          iz_tmo  = 1'b1;
          ph_d    = PH_AZ;
          tmr_clr = 1'b1;
        end
      end
      default: ph_d = PH_AZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_AZ;
      chan_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) chan_q <= start_chan;
    end
  end

  assign phase_a  = ph_q[1];
  assign phase_b  = ph_q[0];
  assign chan_sel = chan_q;

  dss_result #(.W(CNT_W), .LIMIT(DEINT_LIMIT)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_sign (take_sign),
    .sign_in   (cmp_lvl),
    .cap_fall  (cap_fall),
    .fall_cnt  (fall_cnt),
    .cap_over  (cap_over),
    .iz_done   (iz_done),
    .iz_tmo    (iz_tmo),
    .res_valid (res_valid),
    .res_sign  (res_sign),
    .res_count (res_count),
    .res_over  (res_over),
    .res_tmo   (res_tmo)
  );

  a_r2_legal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |->
      (($past(ph_q) == PH_AZ    && ph_q == PH_INT)   ||
       ($past(ph_q) == PH_INT   && ph_q == PH_DEINT) ||
       ($past(ph_q) == PH_DEINT && (ph_q == PH_IZ || ph_q == PH_AZ)) ||
       ($past(ph_q) == PH_IZ    && ph_q == PH_AZ)));

  a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> (ph_q == PH_INT));

  a_r4_int_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_INT && ph_q == PH_DEINT) |-> ($past(t_q) == INT_LAST));

  a_r7_deint_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DEINT) |-> (t_q < LIMIT_V));

  a_r8_iz_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IZ && cmp_lvl) |=> (ph_q == PH_AZ));

  a_r11_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_AZ && $past(ph_q) != PH_AZ) |-> $stable(chan_sel));

endmodule

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;

  localparam int INTC = 20;
  localparam int AZC  = 20;
  localparam int MRG  = 6;
  localparam int IZT  = 10;
  localparam int LIM  = 2 * INTC + MRG;
  localparam int VREF = 10;
  localparam int NSC  = 6;
  localparam int MAXC = 5000;

  logic clk = 1'b0;
  logic rst_n, start_valid, start_ready, cmp_in;
  logic [1:0] start_chan, chan_sel;
  logic phase_a, phase_b, res_valid, res_sign, res_over, res_tmo;
  logic [5:0] res_count;

  always #10 clk = ~clk;

  dual_slope_seq #(
    .INT_CYCLES(INTC), .AZ_CYCLES(AZC), .DEINT_MARGIN(MRG), .IZ_TIMEOUT(IZT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_chan(start_chan), .cmp_in(cmp_in), .phase_a(phase_a), .phase_b(phase_b),
    .chan_sel(chan_sel), .res_valid(res_valid), .res_sign(res_sign),
    .res_count(res_count), .res_over(res_over), .res_tmo(res_tmo)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // scenario table: input step, recovery rate, channel, expected flags
  int sc_vin [NSC] = '{7, -9, 30, 5, -1, 12};
  int sc_z   [NSC] = '{20, 20, 20, 1, 20, 20};
  int sc_ch  [NSC] = '{1, 2, 3, 0, 0, 2};
  int sc_ov  [NSC] = '{0, 0, 1, 0, 0, 0};
  int sc_to  [NSC] = '{0, 0, 0, 1, 0, 0};

  // behavioural reference of the port behaviour
  int m_ph, m_t, m_ch, m_val, m_sign, m_cnt, m_over, m_tmo, m_stg_sign, m_stg_cnt;
  int q1, q2, q3;

  task automatic model_step(output int acc);
    int rdy, fell;
    acc   = 0;
    rdy   = (m_ph == 1 && m_t >= AZC);
    fell  = (q3 == 1 && q2 == 0);
    m_val = 0;
    case (m_ph)
      1: if (start_valid && rdy) begin acc = 1; m_ph = 2; m_t = 0; m_ch = start_chan; end
         else m_t++;
      2: if (m_t == INTC - 1) begin m_stg_sign = q2; m_ph = 3; m_t = 0; end
         else m_t++;
      3: if (fell) begin m_stg_cnt = (m_t >= 1) ? m_t - 1 : 0; m_ph = 0; m_t = 0; end
         else if (m_t == LIM - 1) begin
           m_val = 1; m_sign = m_stg_sign; m_cnt = LIM; m_over = 1; m_tmo = 0; m_ph = 1; m_t = 0;
         end else m_t++;
      default:
         if (q2 == 1) begin
           m_val = 1; m_sign = m_stg_sign; m_cnt = m_stg_cnt; m_over = 0; m_tmo = 0; m_ph = 1; m_t = 0;
         end else if (m_t == IZT - 1) begin
           m_val = 1; m_sign = m_stg_sign; m_cnt = m_stg_cnt; m_over = 0; m_tmo = 1; m_ph = 1; m_t = 0;
         end else m_t++;
    endcase
    q3 = q2; q2 = q1; q1 = cmp_in;
  endtask

  logic [15:0] lf = 16'hACE1;
  function automatic logic noise();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  int integ = 0, ti = 0, dk = 0, d_rec = 0, d_seen = 0, cur = 0, scen = 0, int_len = 0;
  int pos = 1, prev_ph = 1, done = 0, acc = 0;

  initial begin
    m_ph = 1; m_t = 0; m_ch = 0; m_val = 0; m_sign = 0; m_cnt = 0; m_over = 0; m_tmo = 0;
    m_stg_sign = 0; m_stg_cnt = 0; q1 = 0; q2 = 0; q3 = 0;
    rst_n = 1'b0; start_valid = 1'b0; start_chan = 2'd0; cmp_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset phase", {phase_a, phase_b}, 1);
    chk("R1 reset ready", start_ready, 0);
    chk("R1 reset valid", res_valid, 0);
    rst_n = 1'b1;
    start_valid = 1'b1;
    start_chan = sc_ch[0][1:0];
    for (int cyc = 0; cyc < MAXC && !done; cyc++) begin
      int ph;
      string tag;
      @(negedge clk);
      model_step(acc);
      ph = {phase_a, phase_b};
      case (m_ph)
        1: tag = "R12 phase in auto zero";
        2: tag = "R4 phase in integrate";
        3: tag = "R6 phase in deintegrate";
        default: tag = "R8 phase in integrator zero";
      endcase
      chk(tag, ph, m_ph);
      chk("R3 ready", start_ready, (m_ph == 1 && m_t >= AZC));
      chk("R10 strobe", res_valid, m_val);
      chk("R10 sign held", res_sign, m_sign);
      chk("R10 count held", res_count, m_cnt);
      chk("R10 over held", res_over, m_over);
      chk("R10 tmo held", res_tmo, m_tmo);
      chk("R11 channel", chan_sel, m_ch);
      // independent checks derived from the stimulus
      if (ph != prev_ph) begin
        chk("R2 step legal",
            ((prev_ph == 1 && ph == 2) || (prev_ph == 2 && ph == 3) || (prev_ph == 3 && ph == 0) ||
             (prev_ph == 3 && ph == 1) || (prev_ph == 0 && ph == 1)), 1);
        if (prev_ph == 2) chk("R4 integrate length", int_len, INTC);
      end
      if (ph == 2) int_len = (prev_ph == 2) ? int_len + 1 : 1;
      if (acc) begin start_valid = 1'b0; cur = scen; pos = (sc_vin[scen] > 0); end
      if (m_val) begin
        chk("R5 sign", res_sign, pos);
        chk("R11 channel at result", chan_sel, sc_ch[cur]);
        chk("R7 overrange flag", res_over, sc_ov[cur]);
        chk("R9 timeout flag", res_tmo, sc_to[cur]);
        if (sc_ov[cur] != 0) chk("R7 overrange count", res_count, LIM);
        else chk("R6 count", res_count, d_rec);
        scen++;
        if (scen < NSC) begin start_valid = 1'b1; start_chan = sc_ch[scen][1:0]; end
        else done = 1;
      end
      // behavioural front end
      case (ph)
        1: cmp_in = noise();
        2: begin
          if (prev_ph != 2) begin integ = 0; ti = 0; end
          ti++;
          integ += sc_vin[cur];
          cmp_in = (ti <= 5) ? noise() : (integ > 0);
        end
        3: begin
          logic c;
          if (prev_ph != 3) begin dk = 0; d_seen = 0; end
          dk++;
          integ -= pos ? VREF : -VREF;
          c = pos ? (integ > 0) : (integ < 0);
          if (!c && d_seen == 0) begin d_seen = 1; d_rec = dk; end
          cmp_in = c;
        end
        default: begin
          integ += pos ? sc_z[cur] : -sc_z[cur];
          cmp_in = pos ? (integ >= 0) : (integ <= 0);
        end
      endcase
      prev_ph = ph;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d conversions", scen, NSC);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule